// File: doc/BRIEF.md
# Oscillation-count bypass SAR controller

This block sequences the bit cycles of a 12-bit successive-approximation converter. On each accepted comparator result it takes two things: the decision bit and a small count of how many times the ring-oscillator comparator cycled before it decided. A high count means the residue sits close to the comparator threshold. The comparator, the capacitor array and the output code reconstruction sit outside the block.

Three adaptive windows, one each for counts of 2, 3 and 4, decide whether the remaining middle bits can be skipped. When a bypass fires, the sequencer jumps straight to the LSB cycle and parks the skipped bits in the mid (split) DAC state. The LSB result then grades the bypass. A converging result widens the window that fired. A result showing an unresolvable residue narrows that window, restores the skipped bits and resumes ordinary successive approximation from the bit below the one where the bypass fired.

Comparator results arrive over a valid/ready pair. `cmp_ready` is high for the whole of a conversion and low otherwise. A result moves only when `cmp_valid` and `cmp_ready` are both high. Holding `cmp_valid` low stalls the sequence for as long as the source needs, and no internal state changes during the stall.

Top module: `sar_byp_ctrl`

## Requirements
- R1: Reset and `win_clr` each set all three window sizes to 1. Window g occupies `win_sizes[5g+4:5g]` and serves count g+2. When `win_clr` falls in the same cycle as a window update, the clear wins.
- R2: A `samp_done` pulse while idle starts a conversion at bit 11, with `dac_p`, `dac_n` and `skip_mask` all zero and no bypass taken yet. A `samp_done` pulse during a conversion is ignored.
- R3: `cmp_ready` is high exactly while a conversion runs. A cycle without `cmp_valid` changes neither `cyc_en` nor the DAC outputs.
- R4: `cyc_en` is one-hot on the current bit, where index i is bit i and index 11 is the MSB, and it is zero when idle. An accepted decision d at bit i sets `dac_p[i]=d` and `dac_n[i]=!d`. Without a bypass, the next cycle is bit i-1.
- R5: A bypass fires on an accepted decision at bit i≥2 when the count equals 2, 3 or 4, no bypass has fired yet in this conversion, and 2^(i-2) ≤ the size of the selected window. The next cycle is bit 0. Bits i-1..1 stay mid (both DAC lines 0) and are set in `skip_mask`.
- R6: At most one bypass fires per conversion. A count outside 2..4, or a window that fails the size test, leaves the sequence in normal order.
- R7: After a bypass, an LSB result with a nonzero count ends the conversion and raises the window that fired by 1, saturating at 31.
- R8: After a bypass, an LSB result with count 0 pulses `win_err` for one cycle. It also lowers that window by 1 (floor 1), clears `skip_mask`, returns bit 0 to mid and resumes at bit i-1 in normal order.
- R9: `done` is high for exactly one cycle after the final LSB result is accepted, and `cmp_ready` is low in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_clr | input | 1 | Synchronous clear of the window sizes to 1 |
| samp_done | input | 1 | Sampling finished; start a conversion |
| cmp_valid | input | 1 | Comparator result valid |
| cmp_ready | output | 1 | Controller accepts results (converting) |
| cmp_dec | input | 1 | Comparator decision |
| cmp_noc | input | 3 | Oscillation count before the decision |
| cyc_en | output | 12 | One-hot current bit cycle |
| dac_p | output | 12 | Per-bit DAC up control |
| dac_n | output | 12 | Per-bit DAC down control |
| skip_mask | output | 12 | Bits skipped by the pending bypass |
| done | output | 1 | One-cycle end-of-conversion strobe |
| win_err | output | 1 | One-cycle window-too-large flag |
| win_sizes | output | 15 | Three 5-bit window sizes |

## Verification
Two functions can act on the window registers in the same cycle: the grading update at the LSB of a bypassed conversion, and the external `win_clr`. The bench raises `win_clr` on exactly the edge that accepts a converging LSB result after its window has grown. It then expects every window to read 1, not the incremented value. The bench also drives `samp_done` during a stalled mid-conversion cycle and expects the current bit to hold.

// File: rtl/sar_byp_pkg.sv
package sar_byp_pkg;
  localparam int unsigned DEF_BITS     = 12;
  localparam int unsigned DEF_WIN_W    = 5;
  localparam int unsigned DEF_NOC_W    = 3;
  localparam int unsigned DEF_N_WIN    = 3;
  localparam int unsigned DEF_NOC_BASE = 2;

  typedef enum logic [1:0] {
    WUPD_NONE = 2'd0,
    WUPD_INC  = 2'd1,
    WUPD_DEC  = 2'd2
  } win_upd_e;
endpackage

// File: rtl/sar_win_bank.sv
module sar_win_bank
  import sar_byp_pkg::*;
#(
  parameter int unsigned WIN_W = DEF_WIN_W,
  parameter int unsigned N_WIN = DEF_N_WIN,
  localparam int unsigned SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  win_upd_e               upd,
  input  logic [SEL_W-1:0]       sel,
  output logic [N_WIN*WIN_W-1:0] sizes
);
  localparam logic [WIN_W-1:0] W_MIN = WIN_W'(1);
  localparam logic [WIN_W-1:0] W_MAX = '1;

  for (genvar g = 0; g < N_WIN; g++) begin : g_win
    logic [WIN_W-1:0] w_q;
    logic             mine;
    assign mine = (sel == SEL_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        w_q <= W_MIN;
      end else if (clr) begin
        w_q <= W_MIN;
      end else if (mine && upd == WUPD_INC && w_q != W_MAX) begin
        w_q <= w_q + WIN_W'(1);
      end else if (mine && upd == WUPD_DEC && w_q != W_MIN) begin
        w_q <= w_q - WIN_W'(1);
      end
    end

    assign sizes[g*WIN_W +: WIN_W] = w_q;
  end
endmodule

// File: rtl/sar_byp_check.sv
module sar_byp_check
  import sar_byp_pkg::*;
#(
  parameter int unsigned N_BITS   = DEF_BITS,
  parameter int unsigned WIN_W    = DEF_WIN_W,
  parameter int unsigned NOC_W    = DEF_NOC_W,
  parameter int unsigned N_WIN    = DEF_N_WIN,
  parameter int unsigned NOC_BASE = DEF_NOC_BASE,
  localparam int unsigned IDX_W   = $clog2(N_BITS),
  localparam int unsigned SEL_W   = (N_WIN > 1) ? $clog2(N_WIN) : 1
) (
  input  logic [IDX_W-1:0]       cur,
  input  logic [NOC_W-1:0]       noc,
  input  logic [N_WIN*WIN_W-1:0] sizes,
  output logic                   hit,
  output logic [SEL_W-1:0]       hit_sel
);
  logic [N_WIN-1:0] ok;
  logic [N_BITS-1:0] span;

  always_comb begin
    span = '0;
    if (cur >= IDX_W'(2)) span = N_BITS'(1) << (cur - IDX_W'(2));
  end

  for (genvar g = 0; g < N_WIN; g++) begin : g_cmp
    assign ok[g] = (noc == NOC_W'(NOC_BASE + g)) && (cur >= IDX_W'(2)) &&
                   (span <= N_BITS'(sizes[g*WIN_W +: WIN_W]));
  end

  always_comb begin
    hit     = |ok;
    hit_sel = '0;
    for (int g = N_WIN - 1; g >= 0; g--) begin
      if (ok[g]) hit_sel = SEL_W'(g);
    end
  end
endmodule

// File: rtl/sar_byp_ctrl.sv
module sar_byp_ctrl
  import sar_byp_pkg::*;
#(
  parameter int unsigned N_BITS   = DEF_BITS,
  parameter int unsigned WIN_W    = DEF_WIN_W,
  parameter int unsigned NOC_W    = DEF_NOC_W,
  parameter int unsigned N_WIN    = DEF_N_WIN,
  parameter int unsigned NOC_BASE = DEF_NOC_BASE
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   win_clr,
  input  logic                   samp_done,
  input  logic                   cmp_valid,
  output logic                   cmp_ready,
  input  logic                   cmp_dec,
  input  logic [NOC_W-1:0]       cmp_noc,
  output logic [N_BITS-1:0]      cyc_en,
  output logic [N_BITS-1:0]      dac_p,
  output logic [N_BITS-1:0]      dac_n,
  output logic [N_BITS-1:0]      skip_mask,
  output logic                   done,
  output logic                   win_err,
  output logic [N_WIN*WIN_W-1:0] win_sizes
);
  localparam int unsigned IDX_W = $clog2(N_BITS);
  localparam int unsigned SEL_W = (N_WIN > 1) ? $clog2(N_WIN) : 1;

  logic              busy, taken, pend, done_q, err_q;
  logic [IDX_W-1:0]  cur, byp_bit;
  logic [SEL_W-1:0]  byp_sel, hit_sel;
  logic [N_BITS-1:0] up, dn, mask, skip_v;
  logic              acc, at_lsb, lsb_bad, hit;
  win_upd_e          upd;

  assign acc     = cmp_valid && busy;
  assign at_lsb  = (cur == '0);
  assign lsb_bad = pend && (cmp_noc == '0);
  assign skip_v  = ((N_BITS'(1) << cur) - N_BITS'(1)) & ~N_BITS'(1);

  always_comb begin
    upd = WUPD_NONE;
    if (acc && at_lsb && pend) upd = lsb_bad ? WUPD_DEC : WUPD_INC;
  end

  sar_byp_check #(
    .N_BITS(N_BITS), .WIN_W(WIN_W), .NOC_W(NOC_W), .N_WIN(N_WIN), .NOC_BASE(NOC_BASE)
  ) u_check (
    .cur(cur), .noc(cmp_noc), .sizes(win_sizes), .hit(hit), .hit_sel(hit_sel)
  );

  sar_win_bank #(.WIN_W(WIN_W), .N_WIN(N_WIN)) u_bank (
    .clk(clk), .rst_n(rst_n), .clr(win_clr), .upd(upd), .sel(byp_sel), .sizes(win_sizes)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      taken   <= 1'b0;
      pend    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
      cur     <= '0;
      byp_bit <= '0;
      byp_sel <= '0;
      up      <= '0;
      dn      <= '0;
      mask    <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (!busy) begin
        if (samp_done) begin
          busy  <= 1'b1;
          cur   <= IDX_W'(N_BITS - 1);
          taken <= 1'b0;
          pend  <= 1'b0;
          up    <= '0;
          dn    <= '0;
          mask  <= '0;
        end
      end else if (acc) begin
        up[cur] <= cmp_dec;
        dn[cur] <= ~cmp_dec;
        if (at_lsb) begin
          pend <= 1'b0;
          if (lsb_bad) begin
            err_q <= 1'b1;
            mask  <= '0;
            up[0] <= 1'b0;
            dn[0] <= 1'b0;
            cur   <= byp_bit - IDX_W'(1);
          end else begin
            busy   <= 1'b0;
            done_q <= 1'b1;
          end
        end else if (!taken && hit) begin
          taken   <= 1'b1;
          pend    <= 1'b1;
          byp_bit <= cur;
          byp_sel <= hit_sel;
          mask    <= mask | skip_v;
          cur     <= '0;
        end else begin
          cur <= cur - IDX_W'(1);
        end
      end
    end
  end

  assign cmp_ready = busy;
  assign cyc_en    = busy ? (N_BITS'(1) << cur) : '0;
  assign dac_p     = up;
  assign dac_n     = dn;
  assign skip_mask = mask;
  assign done      = done_q;
  assign win_err   = err_q;
endmodule

// File: rtl/sar_byp_chk.sv
module sar_byp_chk #(
  parameter int unsigned N_BITS = 12,
  parameter int unsigned WIN_W  = 5,
  parameter int unsigned NOC_W  = 3,
  parameter int unsigned N_WIN  = 3
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   win_clr,
  input logic                   cmp_valid,
  input logic                   cmp_ready,
  input logic [N_BITS-1:0]      cyc_en,
  input logic [N_BITS-1:0]      dac_p,
  input logic [N_BITS-1:0]      dac_n,
  input logic [N_BITS-1:0]      skip_mask,
  input logic                   done,
  input logic                   win_err,
  input logic [N_WIN*WIN_W-1:0] win_sizes
);
  p_cyc_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cyc_en) && (cmp_ready == (cyc_en != '0)));

  p_stall_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ready && !cmp_valid) |=> ($stable(cyc_en) && $stable(dac_p) && $stable(dac_n)));

  p_skip_mid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_mask & (dac_p | dac_n)) == '0);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmp_ready ##1 !done));

  p_err_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    win_err |-> (cmp_ready && skip_mask == '0 && !done));

  for (genvar g = 0; g < N_WIN; g++) begin : g_w
    p_win_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
      win_clr |=> (win_sizes[g*WIN_W +: WIN_W] == WIN_W'(1)));
    p_win_floor_r8: assert property (@(posedge clk) disable iff (!rst_n)
      win_sizes[g*WIN_W +: WIN_W] != '0);
  end
endmodule

bind sar_byp_ctrl sar_byp_chk #(
  .N_BITS(N_BITS), .WIN_W(WIN_W), .NOC_W(NOC_W), .N_WIN(N_WIN)
) u_chk (
  .clk(clk), .rst_n(rst_n), .win_clr(win_clr), .cmp_valid(cmp_valid),
  .cmp_ready(cmp_ready), .cyc_en(cyc_en), .dac_p(dac_p), .dac_n(dac_n),
  .skip_mask(skip_mask), .done(done), .win_err(win_err), .win_sizes(win_sizes)
);

// File: tb/tb_sar_byp_ctrl.sv
module tb_sar_byp_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        win_clr = 1'b0, samp_done = 1'b0, cmp_valid = 1'b0, cmp_dec = 1'b0;
  logic [2:0]  cmp_noc = 3'd0;
  logic        cmp_ready, done, win_err;
  logic [11:0] cyc_en, dac_p, dac_n, skip_mask;
  logic [14:0] win_sizes;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int w[3];

  always #4 clk = ~clk;

  sar_byp_ctrl dut (
    .clk(clk), .rst_n(rst_n), .win_clr(win_clr), .samp_done(samp_done),
    .cmp_valid(cmp_valid), .cmp_ready(cmp_ready), .cmp_dec(cmp_dec), .cmp_noc(cmp_noc),
    .cyc_en(cyc_en), .dac_p(dac_p), .dac_n(dac_n), .skip_mask(skip_mask),
    .done(done), .win_err(win_err), .win_sizes(win_sizes)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_win(input string req);
    for (int g = 0; g < 3; g++)
      chk(win_sizes[g*5 +: 5] == w[g][4:0], req, "window size",
          32'(win_sizes[g*5 +: 5]), 32'(w[g]));
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // One conversion. bk: bit where count tnoc is first offered; after a bypass
  // fires, tnoc is offered again on every later non-LSB bit (R6).
  task automatic conv(input int bk, input int tnoc, input bit lerr,
                      input bit stall, input bit clr_end, input logic [11:0] pat);
    int cur = 11;
    bit taken = 0, pend = 0, fin = 0, experr;
    int bb = 0, wi = 0, nocv;
    logic [11:0] ep = '0, en = '0, em = '0;
    @(negedge clk) samp_done = 1'b1;
    @(negedge clk) samp_done = 1'b0;
    chk(cmp_ready == 1'b1, "R3", "ready at start", 32'(cmp_ready), 1);
    chk(dac_p == 0 && dac_n == 0 && skip_mask == 0, "R2", "dac cleared at start",
        32'(dac_p | dac_n | skip_mask), 0);
    while (!fin) begin
      chk(cyc_en == (12'd1 << cur), "R4", "current bit", 32'(cyc_en), 32'(12'd1 << cur));
      if (stall && cur == 7) begin
        samp_done = 1'b1;
        @(negedge clk) samp_done = 1'b0;
        chk(cyc_en == (12'd1 << cur), "R2", "samp_done ignored while busy",
            32'(cyc_en), 32'(12'd1 << cur));
        chk(dac_p == ep && dac_n == en, "R3", "stall keeps dac", 32'(dac_p), 32'(ep));
      end
      nocv = (cur == 0) ? ((pend && lerr) ? 0 : 1) : ((cur == bk || taken) ? tnoc : 1);
      cmp_valid = 1'b1;
      cmp_dec   = pat[cur];
      cmp_noc   = 3'(nocv);
      experr    = 0;
      if (clr_end && cur == 0 && !(pend && lerr)) win_clr = 1'b1;
      @(posedge clk);
      ep[cur] = pat[cur];
      en[cur] = ~pat[cur];
      if (cur == 0) begin
        if (pend && nocv == 0) begin
          experr = 1; pend = 0; em = '0; ep[0] = 0; en[0] = 0; cur = bb - 1;
          if (w[wi] > 1) w[wi]--;
        end else begin
          if (pend && w[wi] < 31) w[wi]++;
          pend = 0; fin = 1;
        end
      end else if (!taken && cur >= 2 && nocv >= 2 && nocv <= 4 &&
                   (1 << (cur - 2)) <= w[nocv - 2]) begin
        taken = 1; pend = 1; bb = cur; wi = nocv - 2;
        for (int j = 1; j < cur; j++) em[j] = 1'b1;
        cur = 0;
      end else begin
        cur--;
      end
      if (win_clr) for (int g = 0; g < 3; g++) w[g] = 1;
      @(negedge clk);
      cmp_valid = 1'b0;
      win_clr   = 1'b0;
      chk(win_err == experr, "R8", "error pulse", 32'(win_err), 32'(experr));
      if (!fin)
        chk(skip_mask == em, "R5", "skip mask", 32'(skip_mask), 32'(em));
    end
    chk(done == 1'b1 && cmp_ready == 1'b0, "R9", "done strobe and ready low",
        32'({done, cmp_ready}), 32'h2);
    chk(dac_p == ep && dac_n == en, "R4", "final dac", 32'({dac_p, dac_n}), 32'({ep, en}));
    chk(skip_mask == em, "R5", "final skip mask", 32'(skip_mask), 32'(em));
    chk_win(taken ? (lerr ? "R8" : "R7") : "R6");
    @(negedge clk);
    chk(done == 1'b0 && cyc_en == 0, "R9", "done one cycle", 32'(done), 0);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        summary();
      end
    end
  end

  initial begin
    for (int g = 0; g < 3; g++) w[g] = 1;
    repeat (3) @(negedge clk);
    chk(cmp_ready == 0 && done == 0 && cyc_en == 0, "R3", "idle after reset",
        32'({cmp_ready, done}), 0);
    chk_win("R1");
    rst_n = 1'b1;
    @(negedge clk);
    // normal conversions, stall + ignored start, counts outside 2..4 (R6)
    conv(6, 5, 0, 1, 0, 12'hA5C);
    conv(6, 1, 0, 0, 0, 12'h3C1);
    conv(9, 2, 0, 0, 0, 12'hFFF);
    // sweep all windows across trigger bits, some grading errors
    for (int g = 0; g < 3; g++)
      for (int rep = 0; rep < 40; rep++)
        conv(2 + rep % 10, g + 2, (rep % 5) == 4, 0, 0, 12'(rep * 149 + g * 77));
    // saturation at 31 then floor at 1 (R7, R8)
    for (int rep = 0; rep < 36; rep++) conv(2, 2, 0, 0, 0, 12'(rep * 31));
    chk(w[0] == 31, "R7", "bench window saturated", 32'(w[0]), 31);
    conv(11, 2, 0, 0, 0, 12'h801);
    for (int rep = 0; rep < 36; rep++) conv(2, 2, 1, 0, 0, 12'(rep * 53));
    chk(w[0] == 1, "R8", "bench window floored", 32'(w[0]), 1);
    // clear coinciding with a window increment (R1)
    conv(2, 3, 0, 0, 0, 12'h123);
    conv(2, 3, 0, 0, 0, 12'h456);
    conv(3, 3, 0, 0, 1, 12'h789);
    chk_win("R1");
    // asynchronous reset mid-conversion restores windows (R1)
    conv(2, 4, 0, 0, 0, 12'h0F0);
    @(negedge clk) samp_done = 1'b1;
    @(negedge clk) samp_done = 1'b0;
    rst_n = 1'b0;
    for (int g = 0; g < 3; g++) w[g] = 1;
    @(negedge clk);
    chk(cmp_ready == 0, "R3", "reset ends conversion", 32'(cmp_ready), 0);
    chk_win("R1");
    summary();
  end
endmodule